// File: doc/BRIEF.md
# UART Low-Power State Controller

This block decides when the clocks of a UART core may run. A host-written forced-sleep bit turns off every UART clock domain at once: oscillator, PLL, predivider, receiver and transmitter. The host interface and the register file sit outside this block and keep running. A second host bit arms automatic sleep. While it is set, the block counts character-time ticks. It stops the clocks by itself once three things have held for a configurable number of character times: both FIFOs are empty, no interrupt is pending, and the monitored input pins have not changed.

Any edge on a monitored pin ends automatic sleep, and so does the host clearing the automatic-sleep bit. On every wake the oscillator and PLL restart first. The predivider, receiver and transmitter stay gated until a stabilization count has elapsed, and the clock-ready flag is raised at that same point. When an external clock source is selected, no stabilization time is modelled and readiness follows one cycle after wake.

Top module: `uart_lp_ctrl`

## Requirements
- R1: During reset and immediately after it, the block is waking: `clk_gate_en` is 5'b00011 and `clk_ready` is 0. Bit 0 enables the oscillator, bit 1 the PLL, bit 2 the predivider, bit 3 the receiver and bit 4 the transmitter. After STAB_CYCLES rising edges without reset, `clk_gate_en` becomes 5'b11111 and `clk_ready` becomes 1.
- R2: One edge after `force_sleep` is sampled high, `clk_gate_en` is 5'b00000 and `clk_ready` is 0. This state then holds for as long as `force_sleep` stays high, regardless of pin edges.
- R3: One edge after `force_sleep` is sampled low while force-sleeping, `clk_gate_en` is 5'b00011. STAB_CYCLES edges after that wake, it is 5'b11111 with `clk_ready` 1.
- R4: `char_tick` is a one-cycle pulse per character time. While running and eligible (auto enabled, both FIFOs empty, no interrupt pending), the idle count advances by one per tick. The block enters sleep on the edge after the tick that brings the count to IDLE_CHARS.
- R5: Automatic sleep is never entered while `irq_pending` is 1, while either FIFO is non-empty, or while `auto_sleep_en` is 0.
- R6: A change on any `mon_pins` bit, or a pulse on `fifo_activity`, returns the idle count to zero. Sleep is then entered IDLE_CHARS+1 edges after the edge that sampled the activity, with `char_tick` held high.
- R7: In automatic sleep, an edge on any single `mon_pins` bit gives `clk_gate_en` 5'b00011 one edge later, and readiness after STAB_CYCLES more edges.
- R8: In automatic sleep, clearing `auto_sleep_en` wakes the block one edge later, in the same way as R7.
- R9: With `ext_clk_sel` 1, the stabilization wait is skipped. `clk_ready` is 1 and `clk_gate_en` is 5'b11111 one edge after the wake edge.
- R10: `force_sleep` overrides automatic sleep. Once force-sleeping, pin edges and clearing `auto_sleep_en` leave `clk_gate_en` at 5'b00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst | input | 1 | Synchronous active-high reset |
| force_sleep | input | 1 | Host bit: stop all UART clocks |
| auto_sleep_en | input | 1 | Host bit: allow automatic sleep |
| ext_clk_sel | input | 1 | External clock source selected; no stabilization wait |
| char_tick | input | 1 | One pulse per character time |
| rx_fifo_empty | input | 1 | Receive FIFO holds no words |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no words |
| irq_pending | input | 1 | At least one interrupt is pending |
| fifo_activity | input | 1 | Pulse on any FIFO read or write |
| mon_pins | input | NPINS | Synchronized monitored inputs (GPIO, RX, CTS) |
| clk_gate_en | output | 5 | Clock enables: osc, PLL, predivider, RX, TX (bit 0 to 4) |
| clk_ready | output | 1 | Clocks stable and UART running |

## Verification
Every output is a register loaded from the next state, so a stimulus that changes state shows at the ports exactly one rising edge later. Readiness arrives STAB_CYCLES edges after the wake edge, or one edge after it when the external clock is selected. Automatic entry lands one edge after the tick that fills the idle count, which means edge (IDLE_CHARS-1)*P+2 when ticks arrive every P cycles starting at the first edge. The bench drives inputs a quarter period after each rising edge and checks at that same point, counting edges itself. For each timing it checks both the last cycle before the change and the first cycle after it.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WAKE  = 2'd1,
    ST_SLP_F = 2'd2,
    ST_SLP_A = 2'd3
  } lp_state_t;

  localparam int GATE_W = 5;
  // bit 0 osc, 1 pll, 2 predivider, 3 rx, 4 tx
  localparam logic [GATE_W-1:0] GATE_OFF  = 5'b00000;
  localparam logic [GATE_W-1:0] GATE_WAKE = 5'b00011;
  localparam logic [GATE_W-1:0] GATE_RUN  = 5'b11111;

  function automatic logic [GATE_W-1:0] gate_of(lp_state_t s);
    case (s)
      ST_RUN:  return GATE_RUN;
      ST_WAKE: return GATE_WAKE;
      default: return GATE_OFF;
    endcase
  endfunction
endpackage

// File: rtl/lp_pin_watch.sv
module lp_pin_watch #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins,
  output logic             act
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] diff;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pins;
  end

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_diff
      assign diff[g] = pins[g] ^ prev_q[g];
    end
  endgenerate

  assign act = |diff;
endmodule

// File: rtl/lp_idle_timer.sv
module lp_idle_timer #(
  parameter int LIMIT = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)                cnt <= '0;
    else if (tick && cnt != LIM)   cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);

  // R4
  idle_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);

  // R6
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/lp_stab_timer.sv
module lp_stab_timer #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  // R3
  stab_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/uart_lp_ctrl.sv
module uart_lp_ctrl
  import lp_pkg::*;
#(
  parameter int IDLE_CHARS  = 65536,
  parameter int STAB_CYCLES = 1024,
  parameter int NPINS       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_sleep,
  input  logic              auto_sleep_en,
  input  logic              ext_clk_sel,
  input  logic              char_tick,
  input  logic              rx_fifo_empty,
  input  logic              tx_fifo_empty,
  input  logic              irq_pending,
  input  logic              fifo_activity,
  input  logic [NPINS-1:0]  mon_pins,
  output logic [GATE_W-1:0] clk_gate_en,
  output logic              clk_ready
);
  lp_state_t st, st_nx;
  logic pin_act, idle_done, stab_done;
  logic eligible, idle_clr, auto_go;

  lp_pin_watch #(.NPINS(NPINS)) u_pins (
    .clk (clk), .rst (rst), .pins (mon_pins), .act (pin_act)
  );

  assign eligible = auto_sleep_en && rx_fifo_empty && tx_fifo_empty && !irq_pending;
  assign idle_clr = !eligible || pin_act || fifo_activity || force_sleep || (st != ST_RUN);
  assign auto_go  = idle_done && !idle_clr;

  lp_idle_timer #(.LIMIT(IDLE_CHARS)) u_idle (
    .clk (clk), .rst (rst), .clr (idle_clr), .tick (char_tick), .done (idle_done)
  );

  lp_stab_timer #(.CYCLES(STAB_CYCLES)) u_stab (
    .clk (clk), .rst (rst), .run (st == ST_WAKE), .done (stab_done)
  );

  always_comb begin
    st_nx = st;
    case (st)
      ST_RUN: begin
        if (force_sleep)  st_nx = ST_SLP_F;
        else if (auto_go) st_nx = ST_SLP_A;
      end
      ST_WAKE: begin
        if (force_sleep)                   st_nx = ST_SLP_F;
        else if (stab_done || ext_clk_sel) st_nx = ST_RUN;
      end
      ST_SLP_F: begin
        if (!force_sleep) st_nx = ST_WAKE;
      end
      default: begin
        if (force_sleep)                      st_nx = ST_SLP_F;
        else if (!auto_sleep_en || pin_act)   st_nx = ST_WAKE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_WAKE;
      clk_gate_en <= GATE_WAKE;
      clk_ready   <= 1'b0;
    end else begin
      st          <= st_nx;
      clk_gate_en <= gate_of(st_nx);
      clk_ready   <= (st_nx == ST_RUN);
    end
  end

  // R2
  forced_off_chk: assert property (@(posedge clk) disable iff (rst)
    force_sleep |=> (clk_gate_en == GATE_OFF && !clk_ready));

  // R7
  pin_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SLP_A && pin_act && !force_sleep) |=> (clk_gate_en == GATE_WAKE));

  // R5
  irq_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && irq_pending && !force_sleep) |=> (clk_gate_en == GATE_RUN));

  // R3
  ready_after_wake_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_ready) |-> ($past(clk_gate_en) == GATE_WAKE));
endmodule

// File: tb/sim_uart_lp_ctrl.sv
module sim_uart_lp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 6;
  localparam int STAB = 4;
  localparam int NP   = 3;
  localparam logic [4:0] G_OFF = 5'b00000, G_WAKE = 5'b00011, G_RUN = 5'b11111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic force_sleep = 0, auto_sleep_en = 0, ext_clk_sel = 0, char_tick = 0;
  logic rx_fifo_empty = 1, tx_fifo_empty = 1, irq_pending = 0, fifo_activity = 0;
  logic [NP-1:0] mon_pins = '0;
  logic [4:0] clk_gate_en;
  logic clk_ready;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_lp_ctrl #(.IDLE_CHARS(IDLE), .STAB_CYCLES(STAB), .NPINS(NP)) u0 (
    .clk(clk), .rst(rst), .force_sleep(force_sleep), .auto_sleep_en(auto_sleep_en),
    .ext_clk_sel(ext_clk_sel), .char_tick(char_tick), .rx_fifo_empty(rx_fifo_empty),
    .tx_fifo_empty(tx_fifo_empty), .irq_pending(irq_pending), .fifo_activity(fifo_activity),
    .mon_pins(mon_pins), .clk_gate_en(clk_gate_en), .clk_ready(clk_ready)
  );

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
    end
  endtask

  task automatic expect_out(input string req, input logic [4:0] eg, input logic er);
    checks++;
    if (clk_gate_en !== eg || clk_ready !== er) begin
      errors++;
      $display("FAIL %s: gate=%b ready=%b expected gate=%b ready=%b",
               req, clk_gate_en, clk_ready, eg, er);
    end
  endtask

  task automatic settle_run(input string req);
    step(STAB - 1);
    expect_out(req, G_WAKE, 1'b0);
    step(1);
    expect_out(req, G_RUN, 1'b1);
  endtask

  // R4: ticks every p cycles from the first edge; sleep one edge after the IDLE-th tick
  task automatic enter_auto(input int p, input string req);
    auto_sleep_en = 1'b1;
    for (int i = 1; i <= (IDLE - 1) * p + 1; i++) begin
      char_tick = ((i - 1) % p == 0);
      step(1);
    end
    expect_out(req, G_RUN, 1'b1);
    char_tick = 1'b1;
    step(1);
    expect_out(req, G_OFF, 1'b0);
    char_tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD/4);
    step(3);
    expect_out("R1 in reset", G_WAKE, 1'b0);
    rst = 1'b0;
    expect_out("R1 after reset", G_WAKE, 1'b0);
    settle_run("R1 stabilization");

    // R2 forced sleep, pins ignored
    force_sleep = 1'b1;
    step(1);
    expect_out("R2 forced", G_OFF, 1'b0);
    mon_pins[0] = ~mon_pins[0];
    step(3);
    expect_out("R2 pin ignored", G_OFF, 1'b0);
    // R3 release
    force_sleep = 1'b0;
    step(1);
    expect_out("R3 release", G_WAKE, 1'b0);
    settle_run("R3 ready");

    // R4 sweep over tick spacing
    for (int p = 1; p <= 3; p++) begin
      enter_auto(p, "R4 entry timing");
      auto_sleep_en = 1'b0;
      step(1);
      expect_out("R8 clear auto wakes", G_WAKE, 1'b0);
      settle_run("R8 ready");
    end

    // R7 wake on each pin
    for (int b = 0; b < NP; b++) begin
      enter_auto(1, "R4 entry before pin wake");
      mon_pins[b] = ~mon_pins[b];
      step(1);
      expect_out("R7 pin wake", G_WAKE, 1'b0);
      settle_run("R7 ready");
    end

    // R5 blocking conditions
    auto_sleep_en = 1'b1; char_tick = 1'b1; irq_pending = 1'b1;
    step(3 * IDLE);
    expect_out("R5 irq pending", G_RUN, 1'b1);
    irq_pending = 1'b0; rx_fifo_empty = 1'b0;
    step(3 * IDLE);
    expect_out("R5 rx not empty", G_RUN, 1'b1);
    rx_fifo_empty = 1'b1; tx_fifo_empty = 1'b0;
    step(3 * IDLE);
    expect_out("R5 tx not empty", G_RUN, 1'b1);
    tx_fifo_empty = 1'b1; auto_sleep_en = 1'b0;
    step(3 * IDLE);
    expect_out("R5 auto disabled", G_RUN, 1'b1);

    // R6 restart by pin edge
    auto_sleep_en = 1'b1;
    step(3);
    mon_pins[1] = ~mon_pins[1];
    step(1);
    step(IDLE);
    expect_out("R6 pin restart", G_RUN, 1'b1);
    step(1);
    expect_out("R6 pin restart sleep", G_OFF, 1'b0);
    auto_sleep_en = 1'b0;
    step(1);
    settle_run("R8 ready again");
    // R6 restart by FIFO activity
    auto_sleep_en = 1'b1;
    step(3);
    fifo_activity = 1'b1;
    step(1);
    fifo_activity = 1'b0;
    step(IDLE);
    expect_out("R6 fifo restart", G_RUN, 1'b1);
    step(1);
    expect_out("R6 fifo restart sleep", G_OFF, 1'b0);
    char_tick = 1'b0;

    // R10 forced overrides auto sleep
    force_sleep = 1'b1;
    step(1);
    expect_out("R10 forced from auto", G_OFF, 1'b0);
    mon_pins[2] = ~mon_pins[2];
    step(1);
    expect_out("R10 pin ignored", G_OFF, 1'b0);
    auto_sleep_en = 1'b0;
    step(1);
    expect_out("R10 auto clear ignored", G_OFF, 1'b0);
    force_sleep = 1'b0;
    step(1);
    expect_out("R10 release", G_WAKE, 1'b0);
    settle_run("R10 ready");

    // R9 external clock
    ext_clk_sel = 1'b1;
    force_sleep = 1'b1;
    step(1);
    expect_out("R9 forced", G_OFF, 1'b0);
    force_sleep = 1'b0;
    step(1);
    expect_out("R9 wake", G_WAKE, 1'b0);
    step(1);
    expect_out("R9 fast ready", G_RUN, 1'b1);
    ext_clk_sel = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule